// File: doc/BRIEF.md
# Adaptive page-close idle timer

This block is the page-policy part of a DRAM controller. It remembers, for every bank, whether a row is open and which one, and it sorts each incoming request into one of three cases: the row asked for is already open, the bank has no open row, or a different row is open in that bank. A request to a bank with no open row, or to a different row, leaves that bank open on the requested row. The change of row on a conflict is modelled as a single step.

While a bank is open, the block counts the idle cycles that bank has seen since its last request. When that count reaches an idle limit, the block asks for a precharge of the bank. All banks share one limit. With adaptation switched off, the limit is the programmed value. With adaptation switched on, the limit starts at the programmed value. It then moves up by one after each request that finds its bank closed, and down by one after each request that meets a different open row. The aim is to keep useful rows open longer and to close unhelpful ones sooner.

Command sequencing, refresh and the data path belong to other blocks. This block only classifies requests and raises per-bank precharge requests.

Top module: `page_close_ctl`

## Requirements
- R1: A request to the row that is open in its bank is a hit. In the cycle after the request, `outcome` reads 1. The bank stays open and its idle count restarts from zero.
- R2: A request to a bank with no open row is a miss. In the cycle after the request, `outcome` reads 2. The bank becomes open on the requested row.
- R3: A request to a bank whose open row differs from the requested row is a conflict. In the cycle after the request, `outcome` reads 3. The bank stays open and now holds the requested row.
- R4: `close_req[b]` is high during an idle cycle in which bank b is open, has no request, and has already counted a number of idle cycles equal to the limit. The bank is closed after that cycle. Idle cycles are counted only while `idle` is high. A request to a bank clears its count and holds off its precharge in that cycle.
- R5: With adaptation on, each miss raises the limit by one. The limit saturates at `LIMIT_MAX`, which is 15 by default.
- R6: With adaptation on, each conflict lowers the limit by one. The limit saturates at 0.
- R7: With adaptation off, the limit equals the programmed value, clamped to `LIMIT_MAX`. A programmed value of 0 closes an open bank on its first idle cycle.
- R8: When the programmed value changes or the adaptation enable toggles, the working limit is reloaded from the programmed value. Any earlier adjustment is discarded.
- R9: After reset, every bank is closed, `close_req` is all zero and `outcome` reads 0. `outcome` reads 0 in every cycle that follows a cycle with no request.
- R10: Banks keep their open state and idle counts independently. A request to one bank neither restarts another bank's count nor affects whether that other bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_bank | input | log2(NUM_BANKS) | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| idle | input | 1 | This cycle counts as idle for every open bank without a request |
| init_limit | input | LIMIT_W | Programmed idle limit |
| adapt_en | input | 1 | Enables adjustment of the limit from request outcomes |
| outcome | output | 2 | Class of the previous cycle's request: 0 none, 1 hit, 2 miss, 3 conflict |
| close_req | output | NUM_BANKS | Per-bank precharge request, combinational within the idle cycle |

## Verification
The bench builds the block with its defaults: four banks, 14-bit rows and a 4-bit limit saturating at 15. These values put both ends of the limit within a few dozen cycles. They let the bench push the limit to 15 and show that a further miss holds it there. They also let it drive the limit to 0 and show that a further conflict holds it there. With four banks, the bench can keep two banks open with counts that differ, and show that a hit on one bank leaves the other bank's precharge on time.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

   typedef enum logic [1:0] {
      PG_NONE     = 2'd0,
      PG_HIT      = 2'd1,
      PG_MISS     = 2'd2,
      PG_CONFLICT = 2'd3
   } pg_kind_e;

endpackage

// File: rtl/pcl_bank.sv
module pcl_bank #(
   parameter int ROW_W = 14,
   parameter int CNT_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic [ROW_W-1:0]    row_in,
   input  logic                idle,
   input  logic [CNT_W-1:0]    limit,
   output pcl_pkg::pg_kind_e   kind,
   output logic                close_req
);
   import pcl_pkg::*;

   logic             open_q;
   logic [ROW_W-1:0] row_q;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      if (!sel)                kind = PG_NONE;
      else if (!open_q)        kind = PG_MISS;
      else if (row_q == row_in) kind = PG_HIT;
      else                     kind = PG_CONFLICT;
   end

   assign close_req = open_q && idle && !sel && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
         cnt_q  <= '0;
      end else if (sel) begin
         open_q <= 1'b1;
         row_q  <= row_in;
         cnt_q  <= '0;
      end else if (close_req) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (open_q && idle && (cnt_q < limit)) begin
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/pcl_limit.sv
module pcl_limit #(
   parameter int LIMIT_W   = 4,
   parameter int LIMIT_MAX = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LIMIT_W-1:0] init_limit,
   input  logic               adapt_en,
   input  logic               ev_miss,
   input  logic               ev_conflict,
   output logic [LIMIT_W-1:0] eff_limit
);
   localparam logic [LIMIT_W-1:0] LIM_TOP = LIMIT_W'(LIMIT_MAX);

   logic [LIMIT_W-1:0] lim_q;
   logic [LIMIT_W-1:0] prev_init_q;
   logic               prev_en_q;
   logic [LIMIT_W-1:0] init_c;
   logic               reload;

   assign init_c    = (init_limit > LIM_TOP) ? LIM_TOP : init_limit;
   assign reload    = !adapt_en || (init_limit != prev_init_q) || (adapt_en != prev_en_q);
   assign eff_limit = reload ? init_c : lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q       <= '0;
         prev_init_q <= '0;
         prev_en_q   <= 1'b0;
      end else begin
         prev_init_q <= init_limit;
         prev_en_q   <= adapt_en;
         if (reload)
            lim_q <= init_c;
         else if (ev_miss && (lim_q < LIM_TOP))
            lim_q <= lim_q + LIMIT_W'(1);
         else if (ev_conflict && (lim_q != '0))
            lim_q <= lim_q - LIMIT_W'(1);
      end
   end

endmodule

// File: rtl/page_close_ctl.sv
module page_close_ctl #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 14,
   parameter int LIMIT_W   = 4,
   parameter int LIMIT_MAX = 15,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [BANK_W-1:0]    req_bank,
   input  logic [ROW_W-1:0]     req_row,
   input  logic                 idle,
   input  logic [LIMIT_W-1:0]   init_limit,
   input  logic                 adapt_en,
   output logic [1:0]           outcome,
   output logic [NUM_BANKS-1:0] close_req
);
   import pcl_pkg::*;

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (LIMIT_MAX < 1 || LIMIT_MAX >= (1 << LIMIT_W)) begin : g_bad_limit
      $error("LIMIT_MAX must fit in LIMIT_W bits and be nonzero");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("ROW_W must be positive");
   end

   pg_kind_e           kind_v [NUM_BANKS];
   logic [1:0]         kind_or;
   logic [LIMIT_W-1:0] eff_limit;
   logic [1:0]         outcome_q;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel_b;
      assign sel_b = req_valid && (req_bank == BANK_W'(b));
      pcl_bank #(
         .ROW_W (ROW_W),
         .CNT_W (LIMIT_W)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel       (sel_b),
         .row_in    (req_row),
         .idle      (idle),
         .limit     (eff_limit),
         .kind      (kind_v[b]),
         .close_req (close_req[b])
      );
   end

   always_comb begin
      kind_or = 2'd0;
      for (int i = 0; i < NUM_BANKS; i++)
         kind_or = kind_or | kind_v[i];
   end

   pcl_limit #(
      .LIMIT_W   (LIMIT_W),
      .LIMIT_MAX (LIMIT_MAX)
   ) u_limit (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_limit  (init_limit),
      .adapt_en    (adapt_en),
      .ev_miss     (kind_or == PG_MISS),
      .ev_conflict (kind_or == PG_CONFLICT),
      .eff_limit   (eff_limit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outcome_q <= 2'd0;
      else        outcome_q <= kind_or;
   end

   assign outcome = outcome_q;

endmodule

// File: rtl/pcl_checker.sv
module pcl_checker #(
   parameter int NUM_BANKS = 4,
   parameter int LIMIT_W   = 4,
   parameter int LIMIT_MAX = 15,
   parameter int BANK_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [BANK_W-1:0]    req_bank,
   input logic                 idle,
   input logic                 adapt_en,
   input logic [LIMIT_W-1:0]   init_limit,
   input logic [1:0]           outcome,
   input logic [NUM_BANKS-1:0] close_req,
   input logic [LIMIT_W-1:0]   eff_limit
);

   p_close_only_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|close_req) |-> idle);

   p_no_close_on_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !close_req[req_bank]);

   p_kind_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (outcome != 2'd0));

   p_quiet_without_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (outcome == 2'd0));

   p_limit_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eff_limit <= LIMIT_W'(LIMIT_MAX));

   p_unit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adapt_en && $stable(adapt_en) && $stable(init_limit)) |->
         ((eff_limit == $past(eff_limit)) ||
          (eff_limit == $past(eff_limit) + LIMIT_W'(1)) ||
          (eff_limit + LIMIT_W'(1) == $past(eff_limit))));

endmodule

bind page_close_ctl pcl_checker #(
   .NUM_BANKS (NUM_BANKS),
   .LIMIT_W   (LIMIT_W),
   .LIMIT_MAX (LIMIT_MAX),
   .BANK_W    (BANK_W)
) u_pcl_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_bank   (req_bank),
   .idle       (idle),
   .adapt_en   (adapt_en),
   .init_limit (init_limit),
   .outcome    (outcome),
   .close_req  (close_req),
   .eff_limit  (eff_limit)
);

// File: tb/page_close_ctl_test.sv
`timescale 1ns/1ps
module page_close_ctl_test;

   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_bank = '0;
   logic [13:0]   req_row = '0;
   logic          idle = 1'b0;
   logic [3:0]    init_limit = '0;
   logic          adapt_en = 1'b0;
   logic [1:0]    outcome;
   logic [NB-1:0] close_req;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   page_close_ctl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_bank   (req_bank),
      .req_row    (req_row),
      .idle       (idle),
      .init_limit (init_limit),
      .adapt_en   (adapt_en),
      .outcome    (outcome),
      .close_req  (close_req)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic do_req(input int bank, input int row, input int exp, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_bank = 2'(bank); req_row = 14'(row); idle = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(outcome == 2'(exp), tag, outcome, exp);
   endtask

   task automatic measure(input int bank, input int exp, input string tag);
      int  n = 0;
      bit  seen = 0;
      for (int k = 0; k < 40 && !seen; k++) begin
         @(negedge clk);
         req_valid = 1'b0; idle = 1'b1;
         #1;
         n++;
         if (close_req[bank]) seen = 1;
      end
      @(negedge clk);
      idle = 1'b0;
      chk(seen && n == exp, tag, n, exp);
   endtask

   task automatic flush();
      @(negedge clk);
      adapt_en = 1'b0; init_limit = 4'd0; idle = 1'b1; req_valid = 1'b0;
      @(negedge clk);
      idle = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk(outcome == 2'd0, "R9 outcome in reset", outcome, 0);
      chk(close_req == '0, "R9 close_req in reset", close_req, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      chk(outcome == 2'd0, "R9 outcome after reset", outcome, 0);
      do_req(3, 0, 2, "R9 bank closed after reset");
   endtask

   task automatic t_fixed();
      flush();
      @(negedge clk); init_limit = 4'd3;
      do_req(0, 5, 2, "R2 miss opens bank");
      do_req(0, 5, 1, "R1 hit on open row");
      measure(0, 4, "R4 close after limit 3");
      do_req(0, 5, 2, "R4 bank closed by precharge");
      do_req(0, 9, 3, "R3 conflict on other row");
      do_req(0, 9, 1, "R3 new row recorded");
      measure(0, 4, "R7 limit fixed when off");
      @(negedge clk); init_limit = 4'd0;
      do_req(1, 1, 2, "R2 miss bank1");
      measure(1, 1, "R7 zero limit closes at once");
   endtask

   task automatic t_adapt();
      flush();
      @(negedge clk); adapt_en = 1'b1; init_limit = 4'd2;
      do_req(2, 7, 2, "R5 miss");
      measure(2, 4, "R5 limit raised to 3");
      do_req(2, 7, 2, "R5 miss again");
      do_req(2, 8, 3, "R6 conflict");
      do_req(2, 9, 3, "R6 conflict again");
      measure(2, 3, "R6 limit lowered to 2");
   endtask

   task automatic t_sat_high();
      flush();
      @(negedge clk); adapt_en = 1'b1; init_limit = 4'd14;
      do_req(3, 1, 2, "R5 miss at 14");
      measure(3, 16, "R5 limit 15");
      do_req(3, 1, 2, "R5 miss at 15");
      measure(3, 16, "R5 saturates at 15");
   endtask

   task automatic t_sat_low();
      flush();
      @(negedge clk); adapt_en = 1'b1; init_limit = 4'd1;
      do_req(0, 1, 2, "R6 miss");
      do_req(0, 2, 3, "R6 conflict 1");
      do_req(0, 3, 3, "R6 conflict 2");
      do_req(0, 4, 3, "R6 conflict 3");
      measure(0, 1, "R6 saturates at 0");
   endtask

   task automatic t_reload();
      flush();
      @(negedge clk); adapt_en = 1'b1; init_limit = 4'd1;
      do_req(1, 1, 2, "R8 miss raises to 2");
      @(negedge clk); adapt_en = 1'b0;
      @(negedge clk); adapt_en = 1'b1;
      measure(1, 2, "R8 toggle reloads 1");
      do_req(2, 3, 2, "R8 miss raises to 2");
      @(negedge clk); init_limit = 4'd6;
      measure(2, 7, "R8 new value reloads 6");
   endtask

   task automatic t_banks();
      flush();
      @(negedge clk); init_limit = 4'd2;
      do_req(0, 1, 2, "R10 open bank0");
      do_req(1, 2, 2, "R10 open bank1");
      @(negedge clk); idle = 1'b1; #1;
      chk(close_req == '0, "R4 idle 1 no close", close_req, 0);
      @(negedge clk); #1;
      chk(close_req == '0, "R4 idle 2 no close", close_req, 0);
      @(negedge clk); req_valid = 1'b1; req_bank = 2'd1; req_row = 14'd2; #1;
      chk(close_req == 4'b0001, "R10 bank0 closes during bank1 hit", close_req, 1);
      @(negedge clk); req_valid = 1'b0; #1;
      chk(outcome == 2'd1, "R1 hit with idle high", outcome, 1);
      chk(close_req == '0, "R4 bank1 count restarted", close_req, 0);
      @(negedge clk); #1;
      chk(outcome == 2'd0, "R9 no request no outcome", outcome, 0);
      chk(close_req == '0, "R4 bank1 count 1", close_req, 0);
      @(negedge clk); #1;
      chk(close_req == 4'b0010, "R10 bank1 closes on own count", close_req, 2);
      @(negedge clk); idle = 1'b0;
      do_req(0, 1, 2, "R10 bank0 was closed");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      t_reset();
      t_fixed();
      t_adapt();
      t_sat_high();
      t_sat_low();
      t_reload();
      t_banks();
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule